// File: doc/BRIEF.md
# Display Controller Interrupt Status Unit

This unit gathers event pulses from a display DMA sequencer and records them as sticky bits in two status words. A primary word holds channel-0 frame events together with controller-wide events. A secondary word holds frame events for channels 1 to 6 at fixed per-channel offsets. Two control words hold mask bits, where a bit set to one blocks the matching event from the interrupt. The unit drives a single level-sensitive, registered interrupt line.

When a new unmasked event arrives while the line is already high, the unit sets a secondary-interrupt flag. It also stores that channel's frame ID in an ID register. Software reads all registers through a simple register port and clears status by writing ones. The unit watches the enable bit in control word 0. It reports a quick-disable when software clears that bit. At a frame end with a pending disable request, it drops the enable bit and reports last-frame-done.

Events arrive on a valid-qualified interface that has no ready signal. The unit accepts one event in every cycle with no back-pressure. A producer must therefore present at most one channel event per cycle, and that event is taken in the cycle its valid is high. The controller-wide event pulses and the frame-end pulse are plain single-cycle strobes.

Top module: `lcdis_top`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: Event kind encoding is 0=start-of-frame, 1=end-of-frame, 2=branch, 3=bus error and 4=underrun. Kinds 5–7 and channels of `NUM_CH` or above are ignored.
  - A start-of-frame is recorded only when `ev_sof_en` is high, and an end-of-frame only when `ev_eof_en` is high.
  - Channel 0 start-of-frame and end-of-frame set primary bits 1 and 8.
  - For a channel ch from 1 to 6, start-of-frame sets secondary bit ch-1 and end-of-frame sets secondary bit ch+7.
- R3: Branch events are always recorded. Channel 0 sets primary bit 9, and channel ch from 1 to 6 sets secondary bit ch+15. An underrun on channel 0 sets primary bit 4, on channel 1 primary bit 5, and on channel ch from 2 to 6 secondary bit ch+23.
- R4: A bus error sets primary bit 2 and writes the channel number into primary bits 30:28.
- R5: The controller-wide strobes set primary bits as follows: `acbias_ev` bit 3, `out_under_ev` bit 6, `rd_status_ev` bit 11 and `cmd_done_ev` bit 12.
- R6: `irq` rises or falls one cycle after the status or mask state that causes it. It is the OR of every unmasked primary bit and every secondary bit whose bit in control word 5 is clear.
  - The primary bits and their mask bits in control word 0 are: 0 by 3, 1 by 4, 4 by 5, 6 by 21, 7 by 11, 8 by 6, 9 by 20, 11 by 23 and 12 by 24.
  - Primary bit 5 is masked by control word 5 bit 24.
  - Primary bits 2, 3 and 10 never drive `irq`.
- R7: The secondary-interrupt flag (primary bit 10) is set, and the ID register is loaded with `ev_fid`, when `irq` is already high and either of these arrives:
  - an unmasked start-of-frame, end-of-frame or branch event that is recorded;
  - a bus error, whatever the masks.
- R8: A write to the primary status word clears each of bits 11:0 written as one. Writing one to bit 2 also clears bits 30:28. Bit 12 is not cleared by writes.
- R9: A write to the secondary status word clears only the written-one bits that lie inside mask 0x3E3F3F. Other secondary bits stay set.
- R10: A write to control word 0 that clears bit 0 while bit 0 was set raises quick-disable (primary bit 7). A write to control word 0 that leaves bit 0 clear raises nothing.
- R11: A `frame_end` pulse while control word 0 has both bit 0 and the disable-request bit 10 set does two things: it clears bit 0 and it sets last-frame-done (primary bit 0). A `frame_end` pulse has no effect when bit 0 is clear, or when bit 10 is clear.
- R12: When an event sets a status bit in the same cycle that a write clears it, the bit ends up set.
- R13: The register addresses are:
  - 0: control word 0, which keeps bits 26:0;
  - 1: control word 5, which keeps the bits in 0x3F3F3F3F;
  - 2: primary status;
  - 3: secondary status;
  - 4: ID, which is read-only;
  - any other address reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Channel event present this cycle |
| ev_kind | input | 3 | Event kind code |
| ev_chan | input | CH_W (3) | Channel number of the event |
| ev_fid | input | FID_W (32) | Frame ID of the event's channel |
| ev_sof_en | input | 1 | Channel command enables start-of-frame reporting |
| ev_eof_en | input | 1 | Channel command enables end-of-frame reporting |
| frame_end | input | 1 | End-of-frame strobe for the base plane |
| out_under_ev | input | 1 | Output underrun strobe |
| rd_status_ev | input | 1 | Panel read-status strobe |
| cmd_done_ev | input | 1 | Command interrupt strobe |
| acbias_ev | input | 1 | AC-bias count strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Registered level interrupt |

## Verification
Several behaviours are checked by assertions in every cycle:
- bus-error bit and channel-field capture;
- quick-disable on a clearing write;
- start-of-frame gating by the command enable;
- priority of setting over clearing;
- last-frame-done handling;
- `irq` staying low once both status words are empty.

Some behaviours can only be shown by the bench's scenarios:
- the exact bit placement for each channel and event kind;
- the one-cycle lag of `irq` behind a mask change;
- which secondary bits survive a write-one-to-clear;
- a masked event failing to set the secondary flag while `irq` is high.

// File: rtl/lcdis_pkg.sv
package lcdis_pkg;
  localparam int REG_W = 32;

  typedef enum logic [2:0] {
    EVK_SOF    = 3'd0,
    EVK_EOF    = 3'd1,
    EVK_BRANCH = 3'd2,
    EVK_BUSERR = 3'd3,
    EVK_UNDER  = 3'd4
  } ev_kind_e;

  typedef enum logic [2:0] {
    RA_CTRL0 = 3'd0,
    RA_CTRL5 = 3'd1,
    RA_STAT0 = 3'd2,
    RA_STAT1 = 3'd3,
    RA_IID   = 3'd4
  } reg_addr_e;

  // primary status bit positions
  localparam int S0_LDD  = 0;
  localparam int S0_SOF  = 1;
  localparam int S0_BER  = 2;
  localparam int S0_ACB  = 3;
  localparam int S0_IU0  = 4;
  localparam int S0_IU1  = 5;
  localparam int S0_OU   = 6;
  localparam int S0_QD   = 7;
  localparam int S0_EOF  = 8;
  localparam int S0_BS   = 9;
  localparam int S0_SINT = 10;
  localparam int S0_RDST = 11;
  localparam int S0_CMD  = 12;
  localparam int S0_BCH  = 28;

  // control word 0 bit positions
  localparam int C0_EN    = 0;
  localparam int C0_LDDM  = 3;
  localparam int C0_SOFM  = 4;
  localparam int C0_IUM   = 5;
  localparam int C0_EOFM  = 6;
  localparam int C0_DISRQ = 10;
  localparam int C0_QDM   = 11;
  localparam int C0_BSM   = 20;
  localparam int C0_OUM   = 21;
  localparam int C0_RDSTM = 23;
  localparam int C0_CMDM  = 24;

  // secondary word offsets, position = channel + offset
  localparam int SEC_SOF = -1;
  localparam int SEC_EOF = 7;
  localparam int SEC_BS  = 15;
  localparam int SEC_IU  = 23;
  localparam int C5_IUM1 = 24;

  localparam logic [REG_W-1:0] C0_KEEP  = 32'h07FF_FFFF;
  localparam logic [REG_W-1:0] C5_KEEP  = 32'h3F3F_3F3F;
  localparam logic [REG_W-1:0] S0_W1C   = 32'h0000_0FFF;
  localparam logic [REG_W-1:0] S0_BCH_M = 32'h7000_0000;
  localparam logic [REG_W-1:0] S1_W1C   = 32'h003E_3F3F;
endpackage

// File: rtl/lcdis_event_decode.sv
module lcdis_event_decode
  import lcdis_pkg::*;
#(
  parameter int NUM_CH = 7,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              ev_valid,
  input  logic [2:0]        ev_kind,
  input  logic [CH_W-1:0]   ev_chan,
  input  logic              ev_sof_en,
  input  logic              ev_eof_en,
  input  logic [REG_W-1:0]  ctrl0,
  input  logic [REG_W-1:0]  ctrl5,
  output logic [REG_W-1:0]  set0,
  output logic [REG_W-1:0]  set1,
  output logic              ber_hit,
  output logic              sint_req
);
  logic unmasked;
  logic chan_ok;
  logic is_ch0;
  int   ch;

  always_comb begin
    ch       = int'(ev_chan);
    chan_ok  = ch < NUM_CH;
    is_ch0   = (ch == 0);
    set0     = '0;
    set1     = '0;
    ber_hit  = 1'b0;
    unmasked = 1'b0;
    if (ev_valid && chan_ok) begin
      case (ev_kind)
        EVK_SOF: if (ev_sof_en) begin
          if (is_ch0) begin
            set0[S0_SOF] = 1'b1;
            unmasked     = !ctrl0[C0_SOFM];
          end else begin
            set1[ch+SEC_SOF] = 1'b1;
            unmasked         = !ctrl5[ch+SEC_SOF];
          end
        end
        EVK_EOF: if (ev_eof_en) begin
          if (is_ch0) begin
            set0[S0_EOF] = 1'b1;
            unmasked     = !ctrl0[C0_EOFM];
          end else begin
            set1[ch+SEC_EOF] = 1'b1;
            unmasked         = !ctrl5[ch+SEC_EOF];
          end
        end
        EVK_BRANCH: begin
          if (is_ch0) begin
            set0[S0_BS] = 1'b1;
            unmasked    = !ctrl0[C0_BSM];
          end else begin
            set1[ch+SEC_BS] = 1'b1;
            unmasked        = !ctrl5[ch+SEC_BS];
          end
        end
        EVK_BUSERR: begin
          set0[S0_BER] = 1'b1;
          ber_hit      = 1'b1;
        end
        EVK_UNDER: begin
          if (is_ch0)       set0[S0_IU0] = 1'b1;
          else if (ch == 1) set0[S0_IU1] = 1'b1;
          else              set1[ch+SEC_IU] = 1'b1;
        end
        default: ;
      endcase
    end
    sint_req = unmasked || ber_hit;
  end
endmodule

// File: rtl/lcdis_ctrl.sv
module lcdis_ctrl
  import lcdis_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr0,
  input  logic             wr5,
  input  logic [REG_W-1:0] wdata,
  input  logic             frame_end,
  output logic [REG_W-1:0] ctrl0,
  output logic [REG_W-1:0] ctrl5,
  output logic             qd_set,
  output logic             ldd_set
);
  always_comb begin
    qd_set  = wr0 && ctrl0[C0_EN] && !wdata[C0_EN];
    ldd_set = frame_end && ctrl0[C0_EN] && ctrl0[C0_DISRQ];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl0 <= '0;
      ctrl5 <= '0;
    end else begin
      if (wr0)          ctrl0 <= wdata & C0_KEEP;
      else if (ldd_set) ctrl0[C0_EN] <= 1'b0;
      if (wr5)          ctrl5 <= wdata & C5_KEEP;
    end
  end

  // R11: a disable request at frame end drops the enable bit
  p_last_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && ctrl0[C0_EN] && ctrl0[C0_DISRQ] && !wr0) |=> !ctrl0[C0_EN]);
endmodule

// File: rtl/lcdis_irq_merge.sv
module lcdis_irq_merge
  import lcdis_pkg::*;
(
  input  logic [REG_W-1:0] stat0,
  input  logic [REG_W-1:0] stat1,
  input  logic [REG_W-1:0] ctrl0,
  input  logic [REG_W-1:0] ctrl5,
  output logic             irq_d
);
  logic [REG_W-1:0] open0;

  always_comb begin
    open0          = '0;
    open0[S0_LDD]  = !ctrl0[C0_LDDM];
    open0[S0_SOF]  = !ctrl0[C0_SOFM];
    open0[S0_IU0]  = !ctrl0[C0_IUM];
    open0[S0_IU1]  = !ctrl5[C5_IUM1];
    open0[S0_OU]   = !ctrl0[C0_OUM];
    open0[S0_QD]   = !ctrl0[C0_QDM];
    open0[S0_EOF]  = !ctrl0[C0_EOFM];
    open0[S0_BS]   = !ctrl0[C0_BSM];
    open0[S0_RDST] = !ctrl0[C0_RDSTM];
    open0[S0_CMD]  = !ctrl0[C0_CMDM];
    irq_d = (|(stat0 & open0)) || (|(stat1 & ~ctrl5));
  end
endmodule

// File: rtl/lcdis_top.sv
module lcdis_top
  import lcdis_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int FID_W  = 32,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [2:0]        ev_kind,
  input  logic [CH_W-1:0]   ev_chan,
  input  logic [FID_W-1:0]  ev_fid,
  input  logic              ev_sof_en,
  input  logic              ev_eof_en,
  input  logic              frame_end,
  input  logic              out_under_ev,
  input  logic              rd_status_ev,
  input  logic              cmd_done_ev,
  input  logic              acbias_ev,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  logic [REG_W-1:0] ctrl0, ctrl5, stat0_q, stat1_q, stat0_d, stat1_d;
  logic [REG_W-1:0] set0, set1, clr0, clr1, misc0;
  logic [FID_W-1:0] iid_q;
  logic wr0, wr5, wr_s0, wr_s1;
  logic qd_set, ldd_set, ber_hit, sint_req, sint_hit, irq_d;

  always_comb begin
    wr0   = reg_wr && (reg_addr == RA_CTRL0);
    wr5   = reg_wr && (reg_addr == RA_CTRL5);
    wr_s0 = reg_wr && (reg_addr == RA_STAT0);
    wr_s1 = reg_wr && (reg_addr == RA_STAT1);
  end

  lcdis_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr0(wr0), .wr5(wr5), .wdata(reg_wdata),
    .frame_end(frame_end), .ctrl0(ctrl0), .ctrl5(ctrl5),
    .qd_set(qd_set), .ldd_set(ldd_set)
  );

  lcdis_event_decode #(.NUM_CH(NUM_CH)) u_dec (
    .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_chan(ev_chan),
    .ev_sof_en(ev_sof_en), .ev_eof_en(ev_eof_en), .ctrl0(ctrl0), .ctrl5(ctrl5),
    .set0(set0), .set1(set1), .ber_hit(ber_hit), .sint_req(sint_req)
  );

  lcdis_irq_merge u_irq (
    .stat0(stat0_q), .stat1(stat1_q), .ctrl0(ctrl0), .ctrl5(ctrl5), .irq_d(irq_d)
  );

  always_comb begin
    sint_hit = sint_req && irq;
    misc0 = '0;
    misc0[S0_ACB]  = acbias_ev;
    misc0[S0_OU]   = out_under_ev;
    misc0[S0_RDST] = rd_status_ev;
    misc0[S0_CMD]  = cmd_done_ev;
    misc0[S0_QD]   = qd_set;
    misc0[S0_LDD]  = ldd_set;
    misc0[S0_SINT] = sint_hit;
    clr0 = '0;
    if (wr_s0) clr0 = (reg_wdata & S0_W1C) | (reg_wdata[S0_BER] ? S0_BCH_M : '0);
    clr1 = wr_s1 ? (reg_wdata & S1_W1C) : '0;
    // setting is applied after clearing, so a same-cycle event wins
    stat0_d = (stat0_q & ~clr0) | set0 | misc0;
    if (ber_hit) stat0_d[S0_BCH +: 3] = 3'(ev_chan);
    stat1_d = (stat1_q & ~clr1) | set1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat0_q <= '0;
      stat1_q <= '0;
      iid_q   <= '0;
      irq     <= 1'b0;
    end else begin
      stat0_q <= stat0_d;
      stat1_q <= stat1_d;
      if (sint_hit) iid_q <= ev_fid;
      irq <= irq_d;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CTRL0: reg_rdata = ctrl0;
      RA_CTRL5: reg_rdata = ctrl5;
      RA_STAT0: reg_rdata = stat0_q;
      RA_STAT1: reg_rdata = stat1_q;
      RA_IID:   reg_rdata = REG_W'(iid_q);
      default:  reg_rdata = '0;
    endcase
  end

  // R4: bus error captures its bit and channel
  p_buserr_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind == EVK_BUSERR && int'(ev_chan) < NUM_CH)
      |=> (stat0_q[S0_BER] && stat0_q[S0_BCH +: 3] == 3'($past(ev_chan))));

  // R10: clearing the enable bit raises quick-disable
  p_quick_dis_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && ctrl0[C0_EN] && !reg_wdata[C0_EN]) |=> stat0_q[S0_QD]);

  // R2: start-of-frame without command enable leaves the bit clear
  p_sof_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind == EVK_SOF && ev_chan == '0 && !ev_sof_en && !stat0_q[S0_SOF])
      |=> !stat0_q[S0_SOF]);

  // R12: an event beats a same-cycle clearing write
  p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind == EVK_SOF && ev_chan == '0 && ev_sof_en && wr_s0 && reg_wdata[S0_SOF])
      |=> stat0_q[S0_SOF]);

  // R7: bus error while irq is high sets the secondary flag and ID
  p_sint_buserr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && ev_valid && ev_kind == EVK_BUSERR && int'(ev_chan) < NUM_CH)
      |=> (stat0_q[S0_SINT] && iid_q == $past(ev_fid)));

  // R6: empty status words keep irq low in the next cycle
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat0_q == '0 && stat1_q == '0) |=> !irq);
endmodule

// File: tb/lcdis_top_test.sv
module lcdis_top_test;
  logic clk = 1'b0;
  logic rst_n;
  logic ev_valid, ev_sof_en, ev_eof_en, frame_end;
  logic out_under_ev, rd_status_ev, cmd_done_ev, acbias_ev, reg_wr;
  logic [2:0] ev_kind, ev_chan, reg_addr;
  logic [31:0] ev_fid, reg_wdata, reg_rdata, rv;
  logic irq;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  lcdis_top uut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_chan(ev_chan), .ev_fid(ev_fid), .ev_sof_en(ev_sof_en), .ev_eof_en(ev_eof_en),
    .frame_end(frame_end), .out_under_ev(out_under_ev), .rd_status_ev(rd_status_ev),
    .cmd_done_ev(cmd_done_ev), .acbias_ev(acbias_ev), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // {kind, chan, sof_en, eof_en, expected primary, expected secondary}
  localparam int NV = 14;
  localparam logic [71:0] VEC [NV] = '{
    {3'd0, 3'd0, 1'b1, 1'b0, 32'h0000_0002, 32'h0},
    {3'd0, 3'd0, 1'b0, 1'b1, 32'h0,          32'h0},
    {3'd1, 3'd0, 1'b0, 1'b1, 32'h0000_0100, 32'h0},
    {3'd2, 3'd0, 1'b0, 1'b0, 32'h0000_0200, 32'h0},
    {3'd0, 3'd3, 1'b1, 1'b0, 32'h0,          32'h0000_0004},
    {3'd1, 3'd6, 1'b0, 1'b1, 32'h0,          32'h0000_2000},
    {3'd2, 3'd2, 1'b0, 1'b0, 32'h0,          32'h0002_0000},
    {3'd3, 3'd5, 1'b0, 1'b0, 32'h5000_0004, 32'h0},
    {3'd4, 3'd0, 1'b0, 1'b0, 32'h0000_0010, 32'h0},
    {3'd4, 3'd1, 1'b0, 1'b0, 32'h0000_0020, 32'h0},
    {3'd4, 3'd4, 1'b0, 1'b0, 32'h0,          32'h0800_0000},
    {3'd1, 3'd2, 1'b1, 1'b0, 32'h0,          32'h0},
    {3'd5, 3'd1, 1'b1, 1'b1, 32'h0,          32'h0},
    {3'd0, 3'd7, 1'b1, 1'b1, 32'h0,          32'h0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ev_valid = 0; ev_kind = 0; ev_chan = 0; ev_fid = 0; ev_sof_en = 0; ev_eof_en = 0;
    frame_end = 0; out_under_ev = 0; rd_status_ev = 0; cmd_done_ev = 0; acbias_ev = 0;
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic event_pulse(input logic [2:0] k, input logic [2:0] c,
                             input logic [31:0] f, input logic se, input logic ee);
    @(negedge clk);
    ev_valid = 1; ev_kind = k; ev_chan = c; ev_fid = f; ev_sof_en = se; ev_eof_en = ee;
    @(negedge clk);
    ev_valid = 0; ev_sof_en = 0; ev_eof_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    reg_addr = 0;
    idle_inputs();
    rst_n = 0;
    do_reset();

    // R1 reset state, R13 unused address
    rd(3'd0, rv); check("R1 ctrl0", rv, 0);
    rd(3'd2, rv); check("R1 stat0", rv, 0);
    rd(3'd3, rv); check("R1 stat1", rv, 0);
    rd(3'd4, rv); check("R1 id", rv, 0);
    check("R1 irq", {31'b0, irq}, 0);
    rd(3'd6, rv); check("R13 unused addr", rv, 0);

    // table walk: R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      logic [71:0] v;
      v = VEC[i];
      do_reset();
      event_pulse(v[71:69], v[68:66], 32'h0, v[65], v[64]);
      rd(3'd2, rv); check($sformatf("R2/R3/R4 vec%0d primary", i), rv, v[63:32]);
      rd(3'd3, rv); check($sformatf("R2/R3/R4 vec%0d secondary", i), rv, v[31:0]);
    end

    // R6 irq lag and primary mask
    do_reset();
    event_pulse(3'd0, 3'd0, 32'h0, 1, 0);
    check("R6 irq lags status", {31'b0, irq}, 0);
    @(negedge clk);
    check("R6 irq high", {31'b0, irq}, 1);
    wr(3'd0, 32'h0000_0010);
    check("R6 irq before mask takes effect", {31'b0, irq}, 1);
    @(negedge clk);
    check("R6 irq masked", {31'b0, irq}, 0);

    // R6 secondary mask
    do_reset();
    wr(3'd1, 32'h0000_0004);
    event_pulse(3'd0, 3'd3, 32'h0, 1, 0);
    @(negedge clk);
    check("R6 secondary masked irq", {31'b0, irq}, 0);
    wr(3'd1, 32'h0);
    @(negedge clk);
    check("R6 secondary unmasked irq", {31'b0, irq}, 1);

    // R7 secondary flag and ID
    do_reset();
    event_pulse(3'd0, 3'd0, 32'h0, 1, 0);
    @(negedge clk);
    wr(3'd1, 32'h0000_0200);
    event_pulse(3'd1, 3'd2, 32'h0000_0011, 0, 1);
    rd(3'd2, rv); check("R7 masked event no flag", rv & 32'h400, 0);
    rd(3'd4, rv); check("R7 masked event no id", rv, 0);
    event_pulse(3'd1, 3'd3, 32'hABCD_1234, 0, 1);
    rd(3'd2, rv); check("R7 flag set", rv & 32'h400, 32'h400);
    rd(3'd4, rv); check("R7 id loaded", rv, 32'hABCD_1234);

    // R8 primary write-one-to-clear
    do_reset();
    event_pulse(3'd3, 3'd5, 32'h0, 0, 0);
    event_pulse(3'd0, 3'd0, 32'h0, 1, 0);
    rd(3'd2, rv); check("R8 before clear", rv, 32'h5000_0006);
    wr(3'd2, 32'h0000_0002);
    rd(3'd2, rv); check("R8 clear one bit", rv, 32'h5000_0004);
    wr(3'd2, 32'h0000_0004);
    rd(3'd2, rv); check("R8 bus error clears field", rv, 0);

    // R5 strobes, then R8 bit 12 survives
    do_reset();
    @(negedge clk);
    acbias_ev = 1; out_under_ev = 1; rd_status_ev = 1; cmd_done_ev = 1;
    @(negedge clk);
    acbias_ev = 0; out_under_ev = 0; rd_status_ev = 0; cmd_done_ev = 0;
    rd(3'd2, rv); check("R5 strobes", rv, 32'h0000_1848);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, rv); check("R8 bit 12 not cleared", rv, 32'h0000_1000);

    // R9 secondary clear mask
    do_reset();
    event_pulse(3'd2, 3'd1, 32'h0, 0, 0);
    event_pulse(3'd2, 3'd2, 32'h0, 0, 0);
    event_pulse(3'd0, 3'd1, 32'h0, 1, 0);
    event_pulse(3'd4, 3'd4, 32'h0, 0, 0);
    rd(3'd3, rv); check("R9 before clear", rv, 32'h0803_0001);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, rv); check("R9 after clear", rv, 32'h0801_0000);

    // R10 quick disable, R13 keep masks
    do_reset();
    wr(3'd0, 32'hFFFF_FFFE);
    rd(3'd2, rv); check("R10 no qd when enable already clear", rv, 0);
    rd(3'd0, rv); check("R13 ctrl0 keep", rv, 32'h07FF_FFFE);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, rv); check("R13 ctrl5 keep", rv, 32'h3F3F_3F3F);
    wr(3'd4, 32'h1234_5678);
    rd(3'd4, rv); check("R13 id read-only", rv, 0);
    do_reset();
    wr(3'd0, 32'h1);
    rd(3'd2, rv); check("R10 enable no qd", rv, 0);
    wr(3'd0, 32'h0);
    rd(3'd2, rv); check("R10 qd raised", rv, 32'h80);

    // R11 last frame done
    do_reset();
    wr(3'd0, 32'h0000_0401);
    @(negedge clk); frame_end = 1; @(negedge clk); frame_end = 0;
    rd(3'd0, rv); check("R11 enable dropped", rv, 32'h400);
    rd(3'd2, rv); check("R11 ldd set", rv, 32'h1);
    wr(3'd2, 32'h1);
    @(negedge clk); frame_end = 1; @(negedge clk); frame_end = 0;
    rd(3'd2, rv); check("R11 no ldd when disabled", rv, 0);
    wr(3'd0, 32'h1);
    @(negedge clk); frame_end = 1; @(negedge clk); frame_end = 0;
    rd(3'd0, rv); check("R11 no request keeps enable", rv, 32'h1);
    rd(3'd2, rv); check("R11 no request no ldd", rv, 0);

    // R12 set wins over same-cycle clear
    do_reset();
    @(negedge clk);
    ev_valid = 1; ev_kind = 3'd0; ev_chan = 0; ev_sof_en = 1;
    reg_wr = 1; reg_addr = 3'd2; reg_wdata = 32'h2;
    @(negedge clk);
    ev_valid = 0; ev_sof_en = 0; reg_wr = 0; reg_wdata = 0;
    rd(3'd2, rv); check("R12 set beats clear", rv, 32'h2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule